// File: doc/BRIEF.md
# Dual-Bus Address Event Detector

This block is one event detection channel for on-chip debug. It watches the access strobes of two independent data memory buses in the same cycle and emits a single-cycle event pulse when a qualifying access hits a programmed address. A typical use is a flag location that code writes to mark the start or end of a timed region. Because such a write may travel on either bus, each bus is compared against its own reference register, and both comparators share one bit mask.

Software programs the channel through a small register port. It holds two reference registers, a mask and a control word. The control word sets the enable, the routing of buses to comparators, the accepted access direction, a match condition per comparator and how the two comparator results combine. Once enabled, the channel stays armed and fires on every later qualifying access. A level output flips on each event, so an LED or a scope can see when activity starts and stops.

The control logic is a three-state machine. `ST_OFF` means the channel is disabled. `ST_ARMED` means it is enabled and produced no event in the last cycle. `ST_HIT` means it is enabled and the event output is high this cycle. The transitions work as follows. Any state moves to `ST_OFF` when the enable bit reads 0. Otherwise a qualifying hit moves any state to `ST_HIT`, so `ST_ARMED` goes to `ST_HIT` and `ST_HIT` stays in `ST_HIT` on back-to-back hits. Without a hit, any state moves to `ST_ARMED`, which covers `ST_HIT` going back to `ST_ARMED` and `ST_OFF` going to `ST_ARMED`.

Top module: `dbed_top`

## Requirements
- R1: After reset all four registers read zero, the event output is low, and the toggle output is low.
- R2: The register offsets are: 0 reference A, 1 reference B, 2 mask, 3 control. A write stores the data on the next clock edge. A read returns the addressed register combinationally. Control is 11 bits wide and reads zero-extended, so bits 31..11 read as 0.
- R3: A mask bit of 1 makes that address bit take part in the comparison. A mask bit of 0 ignores that bit. All-ones compares every bit.
- R4: Each comparator has a condition code: 00 fires when the masked address equals the masked reference, 01 fires when they differ, and 10 or 11 never fires. Comparator A uses control bits [4:3] and comparator B uses control bits [6:5].
- R5: Control bits [2:1] select how the results combine: 00 never, 01 comparator A only, 10 comparator B only, 11 A or B.
- R6: Control bits [8:7] select the access direction, where the write strobe is 1 for a write: 00 reads only, 01 writes only, 10 either direction, 11 none.
- R7: Control bits [10:9] route the buses: 00 no bus, 01 bus A to both comparators, 10 bus A to comparator A and bus B to comparator B, 11 bus B to both comparators.
- R8: The event output is high for exactly the one cycle after the clock edge that samples a qualifying access. Hits on both buses in the same cycle give a single pulse. Hits in consecutive cycles keep the output high for consecutive cycles.
- R9: With control bit 0 (enable) clear, no access produces an event.
- R10: The toggle output inverts on every event cycle and holds its level otherwise.
- R11: An access is judged against the register contents held before any register write sampled at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data |
| bus_a_valid | input | 1 | Bus A access strobe |
| bus_a_write | input | 1 | Bus A direction (1 = write) |
| bus_a_addr | input | 32 | Bus A address |
| bus_b_valid | input | 1 | Bus B access strobe |
| bus_b_write | input | 1 | Bus B direction (1 = write) |
| bus_b_addr | input | 32 | Bus B address |
| evt_o | output | 1 | Single-cycle event pulse |
| evt_tgl_o | output | 1 | Level that flips on each event |

## Verification
A register write and a bus access can land on the same clock edge, and the channel must judge the access against the control contents held before that write. The bench provokes this in both directions. It enables the channel in the same cycle as a matching write on the bus, and it disables the channel in the same cycle as a matching access. It expects no pulse in the first case and a pulse in the second. It then checks in the following cycles that the new setting has taken effect.

// File: rtl/dbed_pkg.sv
package dbed_pkg;
    localparam int CTRL_W = 11;
    localparam int CFG_AW = 2;

    typedef enum logic [CFG_AW-1:0] {
        RG_REF_A = 2'd0,
        RG_REF_B = 2'd1,
        RG_MASK  = 2'd2,
        RG_CTRL  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [1:0] bus_sel;
        logic [1:0] acc;
        logic [1:0] cond_b;
        logic [1:0] cond_a;
        logic [1:0] comb;
        logic       en;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_HIT   = 2'd2
    } det_state_e;
endpackage

// File: rtl/dbed_regs.sv
module dbed_regs
    import dbed_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    output logic [DW-1:0]     cfg_rdata,
    output logic [DW-1:0]     ref_a_o,
    output logic [DW-1:0]     ref_b_o,
    output logic [DW-1:0]     mask_o,
    output ctrl_t             ctrl_o
);
    localparam int PAD_W = DW - CTRL_W;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_a_o <= '0;
            ref_b_o <= '0;
            mask_o  <= '0;
            ctrl_o  <= '0;
        end else if (cfg_we) begin
            unique case (reg_sel_e'(cfg_addr))
                RG_REF_A: ref_a_o <= cfg_wdata;
                RG_REF_B: ref_b_o <= cfg_wdata;
                RG_MASK:  mask_o  <= cfg_wdata;
                RG_CTRL:  ctrl_o  <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            endcase
        end
    end

    always_comb begin
        unique case (reg_sel_e'(cfg_addr))
            RG_REF_A: cfg_rdata = ref_a_o;
            RG_REF_B: cfg_rdata = ref_b_o;
            RG_MASK:  cfg_rdata = mask_o;
            RG_CTRL:  cfg_rdata = {{PAD_W{1'b0}}, ctrl_o};
        endcase
    end

    // R2: a write to the mask is visible on the following cycle
    assert_mask_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == RG_MASK) |=> (mask_o == $past(cfg_wdata)));
    // R2: no write leaves the reference A register unchanged
    assert_ref_a_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we) |=> $stable(ref_a_o));
endmodule

// File: rtl/dbed_cmp.sv
module dbed_cmp #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid,
    input  logic          write,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] refv,
    input  logic [AW-1:0] mask,
    input  logic [1:0]    cond,
    input  logic [1:0]    acc,
    output logic          match
);
    logic acc_ok;
    logic eq;
    logic cond_ok;

    assign eq = ((addr ^ refv) & mask) == '0;

    always_comb begin
        unique case (acc)
            2'b00:   acc_ok = !write;
            2'b01:   acc_ok = write;
            2'b10:   acc_ok = 1'b1;
            default: acc_ok = 1'b0;
        endcase
        unique case (cond)
            2'b00:   cond_ok = eq;
            2'b01:   cond_ok = !eq;
            default: cond_ok = 1'b0;
        endcase
    end

    assign match = valid && acc_ok && cond_ok;

    // R3: an all-zero mask makes every address equal
    assert_mask_zero_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && acc == 2'b10 && cond == 2'b00 && mask == '0) |-> match);
    // R6: code 11 accepts no direction
    assert_acc_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == 2'b11) |-> !match);
endmodule

// File: rtl/dbed_fsm.sv
module dbed_fsm
    import dbed_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] comb,
    input  logic       match_a,
    input  logic       match_b,
    output logic       evt_o,
    output logic       tgl_o
);
    det_state_e state_q, state_d;
    logic       hit;

    always_comb begin
        unique case (comb)
            2'b00: hit = 1'b0;
            2'b01: hit = match_a;
            2'b10: hit = match_b;
            2'b11: hit = match_a || match_b;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF, ST_ARMED, ST_HIT: begin
                if (!en)      state_d = ST_OFF;
                else if (hit) state_d = ST_HIT;
                else          state_d = ST_ARMED;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 tgl_o <= 1'b0;
        else if (state_d == ST_HIT) tgl_o <= !tgl_o;
    end

    assign evt_o = (state_q == ST_HIT);

    // R8: an enabled either-comparator hit yields an event next cycle
    assert_evt_follows_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && comb == 2'b11 && (match_a || match_b)) |=> evt_o);
    // R9: no event unless enabled in the sampling cycle
    assert_evt_needs_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> $past(en));
    // R10: toggle flips with each event and holds otherwise
    assert_tgl_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |-> (tgl_o != $past(tgl_o)));
    assert_tgl_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_o |-> $stable(tgl_o));
endmodule

// File: rtl/dbed_top.sv
module dbed_top
    import dbed_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [AW-1:0]     cfg_wdata,
    output logic [AW-1:0]     cfg_rdata,
    input  logic              bus_a_valid,
    input  logic              bus_a_write,
    input  logic [AW-1:0]     bus_a_addr,
    input  logic              bus_b_valid,
    input  logic              bus_b_write,
    input  logic [AW-1:0]     bus_b_addr,
    output logic              evt_o,
    output logic              evt_tgl_o
);
    localparam int NCMP = 2;

    logic [AW-1:0] ref_a, ref_b, mask;
    ctrl_t         ctrl;

    logic          src_v    [NCMP];
    logic          src_w    [NCMP];
    logic [AW-1:0] src_addr [NCMP];
    logic [AW-1:0] cmp_ref  [NCMP];
    logic [1:0]    cmp_cond [NCMP];
    logic [NCMP-1:0] match;

    dbed_regs #(.DW(AW)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .ref_a_o(ref_a), .ref_b_o(ref_b), .mask_o(mask), .ctrl_o(ctrl)
    );

    always_comb begin
        cmp_ref[0]  = ref_a;
        cmp_ref[1]  = ref_b;
        cmp_cond[0] = ctrl.cond_a;
        cmp_cond[1] = ctrl.cond_b;
        unique case (ctrl.bus_sel)
            2'b00: begin
                src_v[0] = 1'b0;        src_v[1] = 1'b0;
                src_w[0] = bus_a_write; src_w[1] = bus_b_write;
                src_addr[0] = bus_a_addr; src_addr[1] = bus_b_addr;
            end
            2'b01: begin
                src_v[0] = bus_a_valid; src_v[1] = bus_a_valid;
                src_w[0] = bus_a_write; src_w[1] = bus_a_write;
                src_addr[0] = bus_a_addr; src_addr[1] = bus_a_addr;
            end
            2'b10: begin
                src_v[0] = bus_a_valid; src_v[1] = bus_b_valid;
                src_w[0] = bus_a_write; src_w[1] = bus_b_write;
                src_addr[0] = bus_a_addr; src_addr[1] = bus_b_addr;
            end
            2'b11: begin
                src_v[0] = bus_b_valid; src_v[1] = bus_b_valid;
                src_w[0] = bus_b_write; src_w[1] = bus_b_write;
                src_addr[0] = bus_b_addr; src_addr[1] = bus_b_addr;
            end
        endcase
    end

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        dbed_cmp #(.AW(AW)) cmp_i (
            .clk(clk), .rst_n(rst_n),
            .valid(src_v[g]), .write(src_w[g]), .addr(src_addr[g]),
            .refv(cmp_ref[g]), .mask(mask), .cond(cmp_cond[g]),
            .acc(ctrl.acc), .match(match[g])
        );
    end

    dbed_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .en(ctrl.en), .comb(ctrl.comb),
        .match_a(match[0]), .match_b(match[1]),
        .evt_o(evt_o), .tgl_o(evt_tgl_o)
    );

    // R7: with no bus routed, no comparator reports a match
    assert_no_route_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.bus_sel == 2'b00) |-> (match == '0));
endmodule

// File: tb/dbed_top_tb_top.sv
module dbed_top_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam logic [31:0] REF_A = 32'h1000_0040;
    localparam logic [31:0] REF_B = 32'h2000_0080;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic bus_a_valid = 1'b0, bus_a_write = 1'b0;
    logic [31:0] bus_a_addr = '0;
    logic bus_b_valid = 1'b0, bus_b_write = 1'b0;
    logic [31:0] bus_b_addr = '0;
    logic evt_o, evt_tgl_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic exp_tgl = 1'b0;
    logic [31:0] cur_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbed_top dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_a_valid(bus_a_valid), .bus_a_write(bus_a_write), .bus_a_addr(bus_a_addr),
        .bus_b_valid(bus_b_valid), .bus_b_write(bus_b_write), .bus_b_addr(bus_b_addr),
        .evt_o(evt_o), .evt_tgl_o(evt_tgl_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic acc_ok(input logic [1:0] acc, input logic w);
        case (acc)
            2'b00: return !w;
            2'b01: return w;
            2'b10: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic cmpf(input logic [31:0] a, input logic [31:0] r,
                                  input logic [31:0] m, input logic [1:0] c);
        logic eq;
        eq = ((a ^ r) & m) == 32'd0;
        case (c)
            2'b00: return eq;
            2'b01: return !eq;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic model(input logic [10:0] ctl, input logic [31:0] m,
            input logic av, input logic aw, input logic [31:0] aa,
            input logic bv, input logic bw, input logic [31:0] ba);
        logic v0, v1, w0, w1, h0, h1;
        logic [31:0] d0, d1;
        case (ctl[10:9])
            2'b00: begin v0 = 0; v1 = 0; w0 = aw; w1 = bw; d0 = aa; d1 = ba; end
            2'b01: begin v0 = av; v1 = av; w0 = aw; w1 = aw; d0 = aa; d1 = aa; end
            2'b10: begin v0 = av; v1 = bv; w0 = aw; w1 = bw; d0 = aa; d1 = ba; end
            default: begin v0 = bv; v1 = bv; w0 = bw; w1 = bw; d0 = ba; d1 = ba; end
        endcase
        h0 = v0 && acc_ok(ctl[8:7], w0) && cmpf(d0, REF_A, m, ctl[4:3]);
        h1 = v1 && acc_ok(ctl[8:7], w1) && cmpf(d1, REF_B, m, ctl[6:5]);
        if (!ctl[0]) return 1'b0;
        case (ctl[2:1])
            2'b00: return 1'b0;
            2'b01: return h0;
            2'b10: return h1;
            default: return h0 || h1;
        endcase
    endfunction

    // called at a negedge; returns at the next negedge with the bus idle
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
        cfg_addr = a; #1;
        check(req, cfg_rdata, exp);
    endtask

    task automatic access(input string req, input logic exp_evt,
            input logic av, input logic aw, input logic [31:0] aa,
            input logic bv, input logic bw, input logic [31:0] ba);
        bus_a_valid = av; bus_a_write = aw; bus_a_addr = aa;
        bus_b_valid = bv; bus_b_write = bw; bus_b_addr = ba;
        @(posedge clk); @(negedge clk);
        bus_a_valid = 0; bus_b_valid = 0;
        if (exp_evt) exp_tgl = !exp_tgl;
        check(req, {31'd0, evt_o}, {31'd0, exp_evt});
        check("R10", {31'd0, evt_tgl_o}, {31'd0, exp_tgl});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [10:0] ctl;
        repeat (3) @(negedge clk);
        // R1: reset state
        rd_chk("R1", 2'd0, 32'd0);
        rd_chk("R1", 2'd1, 32'd0);
        rd_chk("R1", 2'd2, 32'd0);
        rd_chk("R1", 2'd3, 32'd0);
        check("R1", {31'd0, evt_o}, 32'd0);
        check("R1", {31'd0, evt_tgl_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: write and read back, control zero-extended
        wr(2'd3, 32'hFFFF_FFFF);
        rd_chk("R2", 2'd3, 32'h0000_07FF);
        wr(2'd3, 32'd0);
        wr(2'd0, REF_A);
        wr(2'd1, REF_B);
        wr(2'd2, 32'hFFFF_FFFF);
        cur_mask = 32'hFFFF_FFFF;
        rd_chk("R2", 2'd0, REF_A);
        rd_chk("R2", 2'd1, REF_B);
        rd_chk("R2", 2'd2, 32'hFFFF_FFFF);
        rd_chk("R2", 2'd3, 32'd0);

        // R9: disabled channel with otherwise hitting fields
        wr(2'd3, {21'd0, 2'b10, 2'b10, 2'b00, 2'b00, 2'b11, 1'b0});
        access("R9", 1'b0, 1, 1, REF_A, 1, 1, REF_B);

        // R4 R5 R6 R7 R8: sweep over fields and bus patterns
        for (int bs = 0; bs < 4; bs++)
          for (int ac = 0; ac < 4; ac++)
            for (int cb = 0; cb < 4; cb++)
              for (int cd = 0; cd < 4; cd++) begin
                ctl = {bs[1:0], ac[1:0], 2'(3 - cd), cd[1:0], cb[1:0], 1'b1};
                wr(2'd3, {21'd0, ctl});
                for (int s = 0; s < 64; s++) begin
                    logic [31:0] aa, ba;
                    aa = s[2] ? REF_B : REF_A;
                    ba = s[5] ? REF_B : REF_A;
                    access("R4 R5 R6 R7 R8",
                        model(ctl, cur_mask, s[0], s[1], aa, s[3], s[4], ba),
                        s[0], s[1], aa, s[3], s[4], ba);
                end
              end

        // R8: back-to-back hits keep the event high; both buses give one pulse
        ctl = {2'b10, 2'b10, 2'b00, 2'b00, 2'b11, 1'b1};
        wr(2'd3, {21'd0, ctl});
        access("R8", 1'b1, 1, 0, REF_A, 1, 1, REF_B);
        access("R8", 1'b1, 0, 0, REF_A, 1, 0, REF_B);
        access("R8", 1'b0, 0, 0, REF_A, 0, 0, REF_B);

        // R3: mask clears low byte; low-byte differences still hit, bit 8 does not
        wr(2'd2, 32'hFFFF_FF00);
        access("R3", 1'b1, 1, 1, REF_A ^ 32'h0000_00FF, 0, 0, 0);
        access("R3", 1'b0, 1, 1, REF_A ^ 32'h0000_0100, 0, 0, 0);
        access("R3", 1'b1, 0, 0, 0, 1, 0, REF_B ^ 32'h0000_0055);
        wr(2'd2, 32'hFFFF_FFFF);

        // R11: enable written at the same edge as a hit -> no event
        wr(2'd3, {21'd0, ctl[10:1], 1'b0});
        cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = {21'd0, ctl};
        access("R11", 1'b0, 1, 1, REF_A, 0, 0, 0);
        cfg_we = 1'b0;
        access("R11", 1'b1, 1, 1, REF_A, 0, 0, 0);
        // R11: disable written at the same edge as a hit -> event still fires
        cfg_we = 1'b1; cfg_addr = 2'd3; cfg_wdata = {21'd0, ctl[10:1], 1'b0};
        access("R11", 1'b1, 0, 0, 0, 1, 1, REF_B);
        cfg_we = 1'b0;
        access("R11", 1'b0, 0, 0, 0, 1, 1, REF_B);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule